// File: doc/BRIEF.md
# Bit-Stuffed PCM Channel Frame Encoder

This block turns one set of eight radio-control channel values into a self-clocking serial line waveform. A single-cycle start strobe captures the channel values and three header bytes. The block then sends a frame built from the following parts:

- a sync delimiter;
- a byte payload, protected by a reflected CRC-16;
- a closing delimiter;
- idle-high padding.

Every data bit is sent as a short run of fixed-length line elements. A zero is two elements long and a one is three elements long. Each symbol ends with a high element, so a receiver can recover the timing from the line alone. After five consecutive ones in the payload, an extra zero is inserted so the payload can never reproduce the delimiter.

The element duration is `TICK_DIV` clock cycles. A host raises `start_i` for one cycle while the block is idle. It then waits for `done_o`, and may start the next frame on any later cycle. The frame scheduling, the mixing that produces the channel values, and any bus or DMA transfer are outside this block.

Top module: `pcm_frame_encoder`

## Requirements
- R1: While no frame is in progress, and after reset, `line_o` is high, `busy_o` is low and `done_o` is low.
- R2: A data 0 is sent as the line elements low, high. A data 1 is sent as low, low, high. Each element lasts exactly `TICK_DIV` clock cycles. The first element appears `TICK_DIV` cycles after the cycle in which the start is accepted.
- R3: The frame begins and ends with the byte 0x7E, sent MSB first with the symbol encoding. Neither delimiter is bit-stuffed, neither counts toward the run of ones, and neither enters the CRC.
- R4: The payload is sent as 18 bytes, MSB first, in this order:
  - byte 0: channel count;
  - byte 1: receiver number;
  - byte 2: flags;
  - byte 3: 0x00;
  - bytes 4 to 15: twelve packed channel bytes;
  - byte 16: CRC low byte;
  - byte 17: CRC high byte.
- R5: Each signed 12-bit channel value v becomes the 12-bit field (v*3)/4 + 2250. The division truncates toward zero, and only the low 12 bits of the result are kept.
- R6: Channels are packed in pairs (0,1), (2,3), (4,5), (6,7), with A the first channel of the pair and B the second. Each pair gives three bytes:
  - A[7:0];
  - {B[3:0], A[11:8]};
  - B[11:4].
- R7: In the payload, after five consecutive data ones an extra data 0 is inserted and the count of ones restarts. The count carries across byte boundaries, and the inserted zero is sent even after the last payload bit.
- R8: The CRC covers payload bytes 0 to 15 before stuffing. It starts at 0x0000, processes each byte LSB first with the reflected polynomial 0x8408, and has no final inversion.
- R9: After the closing delimiter, high elements are appended until the total element count of the frame is a multiple of 8. `busy_o` stays high through the padding.
- R10: `done_o` is high for exactly one cycle, one element time after the last element of the frame begins. In the same cycle `busy_o` falls.
- R11: A start strobe that arrives while `busy_o` is high is ignored. The frame in progress continues with the values captured at its own start, and no extra `done_o` pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle frame request, accepted only when idle |
| chan_vals_i | input | NUM_CH*VAL_W | Signed channel values, channel k at bits [k*VAL_W +: VAL_W] |
| chan_count_i | input | 8 | Channel-count header byte |
| rx_num_i | input | 8 | Receiver-number header byte |
| flags_i | input | 8 | Flags header byte |
| line_o | output | 1 | Serial line, idle high |
| busy_o | output | 1 | High from an accepted start until done |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The hardest conditions to reach from the ports are a stuffed zero that falls across a byte boundary and one that falls after the last CRC bit. The second can occur only if the CRC itself ends in a run of ones. All-ones header bytes force runs of ones across byte boundaries, and the channel values are chosen to give packed fields with long runs of ones.

The bench builds every expected element stream from its own model, which applies the scaling, packing, CRC and stuffing. It compares the line element by element, so any misplaced stuffed bit shifts the whole tail of the frame and is reported. A start strobe is injected in the middle of a frame with different inputs, to show that the frame in progress keeps the values captured at its start.

// File: rtl/pcm_enc_pkg.sv
// Package: shared constants and the phase type of the PCM frame encoder.
// Assumes a fixed frame layout of 4 header bytes, packed channel pairs and 2 CRC bytes.
package pcm_enc_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPEN,
        PH_DATA,
        PH_CLOSE,
        PH_PAD,
        PH_FIN
    } phase_t;

    localparam logic [7:0]  SYNC_BYTE    = 8'h7E;
    localparam logic [15:0] CRC_POLY_REF = 16'h8408;
    localparam int          HDR_BYTES    = 4;
    localparam int          CRC_BYTES    = 2;
    localparam int          FIELD_W      = 12;
    localparam int          SCALE_OFFS   = 2250;
    localparam int          ONES_LIMIT   = 5;
endpackage

// File: rtl/pcm_tick_gen.sv
// Module: element-rate tick generator.
// Produces a one-cycle tick every DIV cycles while run is high.
// The count is held at zero while run is low, so the first tick comes DIV cycles after run rises.
module pcm_tick_gen #(
    parameter int unsigned DIV = 1600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_direct
            assign tick = run;
        end else begin : g_count
            localparam int CNT_W = $clog2(DIV);
            localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);
            logic [CNT_W-1:0] cnt;

            assign tick = run && (cnt == LAST);

            // Count element cycles and restart after each tick or when idle.
            always_ff @(posedge clk) begin
                if (!rst_n || !run || tick) cnt <= '0;
                else                        cnt <= cnt + 1'b1;
            end

            // Ticks are never back to back when the divider exceeds one (element length, R2).
            assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/pcm_crc16.sv
// Module: reflected CRC-16 accumulator.
// Processes one byte per update LSB first with the reflected polynomial.
// Clear has priority over update.
module pcm_crc16
    import pcm_enc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        upd,
    input  logic [7:0]  data,
    output logic [15:0] crc
);
    // Eight reflected shift steps for one byte.
    function automatic logic [15:0] step_byte(input logic [15:0] c_in, input logic [7:0] d);
        logic [15:0] c;
        c = c_in;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ d[i]) c = (c >> 1) ^ CRC_POLY_REF;
            else             c = c >> 1;
        end
        return c;
    endfunction

    // Hold the running CRC; restart at zero for each frame.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) crc <= '0;
        else if (upd)        crc <= step_byte(crc, data);
    end

    // A new frame never folds a byte into the stale CRC (R8).
    assert_no_clear_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |-> !upd);
    // The CRC is zero at the start of every frame (R8).
    assert_crc_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (crc == 16'h0000));
endmodule

// File: rtl/pcm_payload_mux.sv
// Module: payload byte source.
// Scales each channel to a 12-bit field, packs the fields in pairs into three bytes,
// and selects the payload byte given by idx.
// Assumes NUM_CH is even; an idx past the last byte returns zero.
module pcm_payload_mux
    import pcm_enc_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int VAL_W  = 12,
    parameter int IDX_W  = 5
) (
    input  logic [NUM_CH*VAL_W-1:0] vals,
    input  logic [7:0]              count_b,
    input  logic [7:0]              rx_b,
    input  logic [7:0]              flags_b,
    input  logic [15:0]             crc,
    input  logic [IDX_W-1:0]        idx,
    output logic [7:0]              byte_o
);
    localparam int PAIRS  = NUM_CH / 2;
    localparam int PACK_N = 3 * PAIRS;
    localparam int CRC_LO = HDR_BYTES + PACK_N;
    localparam int EXT_W  = VAL_W + 3;

    logic [FIELD_W-1:0] field [NUM_CH];
    logic [7:0]         pack  [PACK_N];

    genvar k;
    generate
        for (k = 0; k < NUM_CH; k++) begin : g_scale
            logic signed [EXT_W-1:0] ext;
            logic signed [EXT_W-1:0] scaled;
            // Scale one channel by three quarters (truncating) and add the offset.
            always_comb begin
                ext    = EXT_W'($signed(vals[k*VAL_W +: VAL_W]));
                scaled = (ext * EXT_W'(3)) / EXT_W'(4) + EXT_W'(SCALE_OFFS);
            end
            assign field[k] = scaled[FIELD_W-1:0];
        end
        for (k = 0; k < PAIRS; k++) begin : g_pack
            assign pack[3*k]     = field[2*k][7:0];
            assign pack[3*k + 1] = {field[2*k+1][3:0], field[2*k][11:8]};
            assign pack[3*k + 2] = field[2*k+1][11:4];
        end
    endgenerate

    // Select the payload byte at the current index.
    always_comb begin
        byte_o = 8'h00;
        if (idx == IDX_W'(0))      byte_o = count_b;
        else if (idx == IDX_W'(1)) byte_o = rx_b;
        else if (idx == IDX_W'(2)) byte_o = flags_b;
        for (int j = 0; j < PACK_N; j++)
            if (idx == IDX_W'(HDR_BYTES + j)) byte_o = pack[j];
        if (idx == IDX_W'(CRC_LO))     byte_o = crc[7:0];
        if (idx == IDX_W'(CRC_LO + 1)) byte_o = crc[15:8];
    end
endmodule

// File: rtl/pcm_frame_encoder.sv
// Module: top of the PCM frame encoder.
// Captures the inputs on an accepted start and walks the frame phases:
// open delimiter, stuffed payload, close delimiter, padding.
// One line element is emitted per tick; the current data bit is derived
// combinationally from the phase and indices, so the CRC bytes see the
// CRC register after its last update.
module pcm_frame_encoder
    import pcm_enc_pkg::*;
#(
    parameter int unsigned TICK_DIV = 1600,
    parameter int          NUM_CH   = 8,
    parameter int          VAL_W    = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [NUM_CH*VAL_W-1:0] chan_vals_i,
    input  logic [7:0]              chan_count_i,
    input  logic [7:0]              rx_num_i,
    input  logic [7:0]              flags_i,
    output logic                    line_o,
    output logic                    busy_o,
    output logic                    done_o
);
    localparam int PAY_N    = HDR_BYTES + 3 * (NUM_CH / 2) + CRC_BYTES;
    localparam int IDX_W    = $clog2(PAY_N + 1);
    localparam int CRC_FIRST = PAY_N - CRC_BYTES;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAY_N - 1);
    localparam logic [IDX_W-1:0] END_IDX  = IDX_W'(PAY_N);

    phase_t                  phase;
    logic [IDX_W-1:0]        byte_idx;
    logic [2:0]              bit_idx;
    logic [2:0]              ones_cnt;
    logic                    stuff_pend;
    logic [1:0]              elem_pos;
    logic [2:0]              elem_cnt;
    logic [NUM_CH*VAL_W-1:0] lat_vals;
    logic [7:0]              lat_count, lat_rx, lat_flags;

    logic        tick, accept;
    logic [15:0] crc;
    logic [7:0]  cur_byte;
    logic        data_bit, sym_bit, elem_val, sym_last, byte_last, crc_upd;
    logic [2:0]  ones_next;

    assign accept = start_i && !busy_o;

    pcm_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(busy_o), .tick(tick)
    );

    pcm_payload_mux #(.NUM_CH(NUM_CH), .VAL_W(VAL_W), .IDX_W(IDX_W)) u_pay (
        .vals(lat_vals), .count_b(lat_count), .rx_b(lat_rx), .flags_b(lat_flags),
        .crc(crc), .idx(byte_idx), .byte_o(cur_byte)
    );

    pcm_crc16 u_crc (
        .clk(clk), .rst_n(rst_n), .clear(accept), .upd(crc_upd),
        .data(cur_byte), .crc(crc)
    );

    // Derive the current symbol bit, its element value, and the symbol and byte ends.
    always_comb begin
        byte_last = (bit_idx == 3'd7);
        data_bit  = stuff_pend ? 1'b0 : cur_byte[3'd7 - bit_idx];
        sym_bit   = (phase == PH_DATA) ? data_bit : SYNC_BYTE[3'd7 - bit_idx];
        elem_val  = !((elem_pos == 2'd0) || (sym_bit && elem_pos == 2'd1));
        sym_last  = sym_bit ? (elem_pos == 2'd2) : (elem_pos == 2'd1);
        ones_next = data_bit ? ones_cnt + 3'd1 : 3'd0;
        crc_upd   = tick && (phase == PH_DATA) && sym_last && !stuff_pend
                    && byte_last && (byte_idx < IDX_W'(CRC_FIRST));
    end

    // Capture the frame inputs once per accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_vals  <= '0;
            lat_count <= '0;
            lat_rx    <= '0;
            lat_flags <= '0;
        end else if (accept) begin
            lat_vals  <= chan_vals_i;
            lat_count <= chan_count_i;
            lat_rx    <= rx_num_i;
            lat_flags <= flags_i;
        end
    end

    // Step the frame phases and emit one line element per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            byte_idx   <= '0;
            bit_idx    <= '0;
            ones_cnt   <= '0;
            stuff_pend <= 1'b0;
            elem_pos   <= '0;
            elem_cnt   <= '0;
            line_o     <= 1'b1;
            busy_o     <= 1'b0;
            done_o     <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (accept) begin
                phase      <= PH_OPEN;
                byte_idx   <= '0;
                bit_idx    <= '0;
                ones_cnt   <= '0;
                stuff_pend <= 1'b0;
                elem_pos   <= '0;
                elem_cnt   <= '0;
                busy_o     <= 1'b1;
            end else if (tick) begin
                unique case (phase)
                    PH_OPEN, PH_DATA, PH_CLOSE: begin
                        line_o   <= elem_val;
                        elem_cnt <= elem_cnt + 3'd1;
                        if (!sym_last) begin
                            elem_pos <= elem_pos + 2'd1;
                        end else begin
                            elem_pos <= '0;
                            if (phase == PH_OPEN) begin
                                bit_idx <= bit_idx + 3'd1;
                                if (byte_last) begin
                                    phase    <= PH_DATA;
                                    byte_idx <= '0;
                                    ones_cnt <= '0;
                                end
                            end else if (phase == PH_CLOSE) begin
                                bit_idx <= bit_idx + 3'd1;
                                if (byte_last)
                                    phase <= (elem_cnt == 3'd7) ? PH_FIN : PH_PAD;
                            end else if (stuff_pend) begin
                                stuff_pend <= 1'b0;
                                if (byte_idx == END_IDX) phase <= PH_CLOSE;
                            end else begin
                                bit_idx <= bit_idx + 3'd1;
                                if (byte_last) byte_idx <= byte_idx + 1'b1;
                                if (ones_next == 3'(ONES_LIMIT)) begin
                                    stuff_pend <= 1'b1;
                                    ones_cnt   <= '0;
                                end else begin
                                    ones_cnt <= ones_next;
                                    if (byte_last && byte_idx == LAST_IDX) phase <= PH_CLOSE;
                                end
                            end
                        end
                    end
                    PH_PAD: begin
                        line_o   <= 1'b1;
                        elem_cnt <= elem_cnt + 3'd1;
                        if (elem_cnt == 3'd7) phase <= PH_FIN;
                    end
                    PH_FIN: begin
                        line_o <= 1'b1;
                        busy_o <= 1'b0;
                        done_o <= 1'b1;
                        phase  <= PH_IDLE;
                    end
                    default: ;
                endcase
            end
        end
    end

    // The idle line stays high (R1).
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> line_o);
    // The done pulse is a single cycle (R10).
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // Done comes exactly as busy falls (R10).
    assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));
    // A frame always ends on a multiple of eight elements (R9).
    assert_pad_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (elem_cnt == 3'd0));
    // A start while busy leaves the captured inputs untouched (R11).
    assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(lat_vals) && $stable(lat_count)
                                 && $stable(lat_rx) && $stable(lat_flags)));
    // The run of ones never reaches the limit without a pending stuffed zero (R7).
    assert_ones_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ones_cnt < 3'(ONES_LIMIT));
endmodule

// File: tb/pcm_frame_encoder_test.sv
// Bench: directed scenarios, each task checks its own frame against a model
// built from the requirements.
module pcm_frame_encoder_test;
    localparam int DIV    = 4;
    localparam int NCH    = 8;
    localparam int VW     = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [NCH*VW-1:0] chan_vals_i = '0;
    logic [7:0] chan_count_i = '0, rx_num_i = '0, flags_i = '0;
    logic line_o, busy_o, done_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int done_seen = 0;
    int exp_q[$];

    always #2.5 clk = ~clk;

    pcm_frame_encoder #(.TICK_DIV(DIV), .NUM_CH(NCH), .VAL_W(VW)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_vals_i(chan_vals_i),
        .chan_count_i(chan_count_i), .rx_num_i(rx_num_i), .flags_i(flags_i),
        .line_o(line_o), .busy_o(busy_o), .done_o(done_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (done_o) done_seen <= done_seen + 1;
    end

    initial begin
        wait (cycles > 150000);
        failures++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual cycles=%0d expected < 150000", cycles);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int fld(input logic [VW-1:0] v);
        int s;
        s = ($signed(v) * 3) / 4 + 2250;
        return s & 32'hFFF;
    endfunction

    function automatic logic [15:0] crc_model(input logic [7:0] b [16]);
        logic [15:0] c = 16'h0000;
        for (int n = 0; n < 16; n++)
            for (int i = 0; i < 8; i++)
                c = (((c ^ 16'(b[n] >> i)) & 16'h1) != 0) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
        return c;
    endfunction

    task automatic push_sym(input bit b);
        exp_q.push_back(0);
        if (b) exp_q.push_back(0);
        exp_q.push_back(1);
    endtask

    task automatic build(input logic [NCH*VW-1:0] vals, input logic [7:0] n, r, f);
        logic [7:0] pay [18];
        logic [7:0] first [16];
        logic [15:0] c;
        int ones;
        exp_q.delete();
        pay[0] = n; pay[1] = r; pay[2] = f; pay[3] = 8'h00;
        for (int p = 0; p < 4; p++) begin
            int a, b;
            a = fld(vals[(2*p)*VW +: VW]);
            b = fld(vals[(2*p+1)*VW +: VW]);
            pay[4+3*p] = 8'(a);
            pay[5+3*p] = 8'(((b & 15) << 4) | ((a >> 8) & 15));
            pay[6+3*p] = 8'(b >> 4);
        end
        for (int i = 0; i < 16; i++) first[i] = pay[i];
        c = crc_model(first);
        pay[16] = c[7:0];
        pay[17] = c[15:8];
        for (int i = 7; i >= 0; i--) push_sym(8'h7E >> i);
        ones = 0;
        for (int k = 0; k < 18; k++)
            for (int i = 7; i >= 0; i--) begin
                bit b;
                b = pay[k][i];
                push_sym(b);
                ones = b ? ones + 1 : 0;
                if (ones == 5) begin push_sym(1'b0); ones = 0; end
            end
        for (int i = 7; i >= 0; i--) push_sym(8'h7E >> i);
        while (exp_q.size() % 8 != 0) exp_q.push_back(1);
    endtask

    // Run one frame and compare it element by element; poke >= 0 injects a start while busy.
    task automatic run_frame(input logic [NCH*VW-1:0] vals, input logic [7:0] n, r, f,
                             input int poke, input string name);
        int mism = 0, first_bad = -1, act_bad = 0, exp_bad = 0, done0;
        bit busy_ok = 1;
        build(vals, n, r, f);
        @(negedge clk);
        chan_vals_i = vals; chan_count_i = n; rx_num_i = r; flags_i = f;
        start_i = 1'b1;
        @(posedge clk);
        done0 = done_seen;
        @(negedge clk);
        start_i = 1'b0;
        for (int j = 0; j < exp_q.size(); j++) begin
            repeat (DIV) begin @(negedge clk); start_i = 1'b0; end
            if (int'(line_o) != exp_q[j]) begin
                if (first_bad < 0) begin first_bad = j; act_bad = line_o; exp_bad = exp_q[j]; end
                mism++;
            end
            if (!busy_o) busy_ok = 0;
            if (j == poke) begin
                start_i = 1'b1;
                chan_vals_i = ~vals; chan_count_i = ~n; rx_num_i = ~r; flags_i = ~f;
            end
        end
        chk(mism == 0, {name, " R2/R4/R5/R6/R7/R8 element stream, first bad index ",
                        $sformatf("%0d", first_bad)}, act_bad, exp_bad);
        chk(busy_ok, {name, " R9 busy held through padding"}, 0, 1);
        repeat (DIV) @(negedge clk);
        chk(done_o == 1'b1, {name, " R10 done after last element"}, done_o, 1);
        chk(busy_o == 1'b0, {name, " R10 busy falls with done"}, busy_o, 0);
        @(negedge clk);
        chk(done_o == 1'b0 && line_o == 1'b1, {name, " R10/R1 done single cycle, line idle"},
            {done_o, line_o}, 1);
        chk(done_seen - done0 == 1, {name, " R11 exactly one done"}, done_seen - done0, 1);
    endtask

    function automatic logic [NCH*VW-1:0] pack_vals(input int v [NCH]);
        logic [NCH*VW-1:0] o;
        for (int k = 0; k < NCH; k++) o[k*VW +: VW] = VW'(v[k]);
        return o;
    endfunction

    task automatic test_reset();
        repeat (3) @(negedge clk);
        chk(line_o == 1'b1, "R1 reset line high", line_o, 1);
        chk(busy_o == 1'b0, "R1 reset busy low", busy_o, 0);
        chk(done_o == 1'b0, "R1 reset done low", done_o, 0);
    endtask

    // R3: the first 22 elements are the open delimiter 0,1,1,1,1,1,1,0 as symbols.
    task automatic test_open_delim();
        int v [NCH] = '{0, 0, 0, 0, 0, 0, 0, 0};
        int pat [22] = '{0,1, 0,0,1, 0,0,1, 0,0,1, 0,0,1, 0,0,1, 0,0,1, 0,1};
        int bad = 0;
        @(negedge clk);
        chan_vals_i = pack_vals(v); chan_count_i = 8'hFF; rx_num_i = 8'hFF; flags_i = 8'hFF;
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        for (int j = 0; j < 22; j++) begin
            repeat (DIV) @(negedge clk);
            if (int'(line_o) != pat[j]) bad++;
        end
        chk(bad == 0, "R3 open delimiter unstuffed", bad, 0);
        wait (done_o);
        @(negedge clk);
    endtask

    // R5: the centre value maps to 2250 = 0x8CA, giving packed bytes CA, A8, 8C.
    task automatic test_zero_values();
        int v [NCH] = '{0, 0, 0, 0, 0, 0, 0, 0};
        chk(fld(12'd0) == 2250, "R5 model centre field", fld(12'd0), 2250);
        run_frame(pack_vals(v), 8'd8, 8'd1, 8'h00, -1, "zero");
    endtask

    task automatic test_mixed();
        int v [NCH] = '{-3, 5, 100, -100, 1023, -1024, 7, -7};
        run_frame(pack_vals(v), 8'd6, 8'd3, 8'h20, -1, "mixed");
    endtask

    // R7: all-ones header bytes force runs of ones across byte boundaries.
    task automatic test_stuffing();
        int v [NCH] = '{2047, -2048, 1845, 2047, -1, 1, 2047, 2047};
        run_frame(pack_vals(v), 8'hFF, 8'hFF, 8'hFF, -1, "stuff");
    endtask

    task automatic test_extremes();
        int v [NCH] = '{-2048, 2047, -2048, 2047, -2048, 2047, -2048, 2047};
        chk(fld(12'h800) == 714, "R5 model negative truncation", fld(12'h800), 714);
        run_frame(pack_vals(v), 8'h01, 8'h7E, 8'h80, -1, "extreme");
    endtask

    // R11: a start with different inputs arrives mid-frame and must be ignored.
    task automatic test_busy_start();
        int v [NCH] = '{11, 22, 33, 44, 55, 66, 77, 88};
        run_frame(pack_vals(v), 8'd4, 8'd9, 8'h10, 40, "busy_start");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_open_delim();
        test_zero_values();
        test_mixed();
        test_stuffing();
        test_extremes();
        test_busy_start();
        test_zero_values();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule